// File: doc/BRIEF.md
# Workgroup Grid Completion Tracker

This block keeps the per-kernel accounting that turns a three-dimensional problem size into a grid of workgroups. A start strobe captures the three global sizes, the three workgroup sizes and a notification address. Three sequential dividers then compute, for each axis, how many workgroups are needed to cover the global size. The count is rounded up, so a partial workgroup at the far edge still counts. The grid total is the product of the three axis counts.

Once the divides are finished, the block raises `ready` and presents the coordinates of the next workgroup to hand out. Each accepted issue strobe steps to the next coordinate, and the block clears `wg_remain` after the last one. Completion is counted separately from issue. Each completion strobe adds one to a tally. When the tally reaches the grid total, the kernel is marked finished and single-cycle requests go out: one to decrement the host's outstanding-dispatch counter, and, if the captured address is nonzero, one to write the notification flag.

A zero workgroup size on any axis is flagged as a configuration error. In that case the kernel finishes at once with an empty grid.

Top module: `wg_grid_tracker`

## Requirements
- R1: The workgroup count on each axis is ceil(global/wg). The number of issue strobes accepted before `wg_remain` clears equals the product of the three counts.
- R2: A start strobe clears the three coordinates, `wg_linear`, the completion tally and `kernel_done`, and sets `wg_remain`. A start is accepted in any state, including during a running kernel.
- R3: `ready` is low while the divides run. Issue strobes seen while `ready` is low leave the coordinates and `wg_linear` unchanged.
- R4: Each accepted issue advances x first. On wrap of x it advances y, and on wrap of y it advances z. `wg_linear` rises by one per accepted issue, so it equals x + ex*(y + ey*z).
- R5: After the final accepted issue, `wg_remain` stays low and the coordinates hold on the last workgroup. Further issue strobes are ignored.
- R6: Each completion strobe seen while `ready` is high adds one to the tally. When the tally equals the total, `kernel_done` goes high, `ready` goes low and `done_pulse` is high for exactly one cycle. Later completion strobes raise no further pulse.
- R7: `dec_req` pulses together with every `done_pulse`. `notify_req` pulses with it only when the address captured at start is nonzero. `notify_addr_o` shows that captured address.
- R8: A zero workgroup size on any axis sets `cfg_error` and finishes the kernel with a total of zero. `wg_remain` is low and exactly one `done_pulse` is raised.
- R9: A zero global size on an axis with valid workgroup sizes finishes the kernel with one `done_pulse` and no issues, and `cfg_error` stays low.
- R10: After reset, `ready`, `wg_remain`, `kernel_done`, `done_pulse`, `notify_req`, `dec_req` and `cfg_error` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture sizes and address, begin a new kernel |
| gsize_x | input | DIM_W | Global size, x axis |
| gsize_y | input | DIM_W | Global size, y axis |
| gsize_z | input | DIM_W | Global size, z axis |
| wsize_x | input | DIM_W | Workgroup size, x axis |
| wsize_y | input | DIM_W | Workgroup size, y axis |
| wsize_z | input | DIM_W | Workgroup size, z axis |
| notify_addr | input | ADDR_W | Flag address to write on completion (0 = none) |
| wg_issue | input | 1 | Current workgroup has been handed out |
| wg_done | input | 1 | One workgroup has finished |
| ready | output | 1 | Grid known, kernel running |
| wg_id_x | output | DIM_W | Coordinate of next workgroup, x |
| wg_id_y | output | DIM_W | Coordinate of next workgroup, y |
| wg_id_z | output | DIM_W | Coordinate of next workgroup, z |
| wg_linear | output | 3*DIM_W | Linear index of next workgroup |
| wg_remain | output | 1 | Workgroups still to issue |
| kernel_done | output | 1 | Kernel finished (level) |
| done_pulse | output | 1 | One-cycle completion pulse |
| cfg_error | output | 1 | A workgroup size was zero |
| notify_req | output | 1 | Request to write 1 to the notify address |
| notify_addr_o | output | ADDR_W | Notify address captured at start |
| dec_req | output | 1 | Request to decrement the host dispatch counter |

## Verification
The grid walk is tried with a shape where every axis leaves a partial workgroup, so rounding down on any axis would shorten the issue sequence. It is also tried with an exact-multiple shape, which exposes an off-by-one rounding up, and with a lopsided shape whose x and z axes have a single workgroup, which exposes mistakes in the carry from one axis to the next. Completion counting is tried one strobe short of the total and then with surplus strobes, to check for early or repeated pulses. A zero-address kernel separates the notify request from the decrement request. The error case (zero workgroup size) and the empty-grid case (zero global size) are told apart by `cfg_error`. A restart in the middle of a run shows that start clears all progress.

// File: rtl/wgt_pkg.sv
package wgt_pkg;
  localparam int WGT_NDIM = 3;

  typedef enum logic [1:0] {
    WGT_IDLE = 2'd0,
    WGT_DIV  = 2'd1,
    WGT_RUN  = 2'd2
  } wgt_state_e;
endpackage

// File: rtl/wgt_ceil_div.sv
// Sequential ceiling divide: quo = ceil(num / den), one quotient bit per cycle.
module wgt_ceil_div #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         busy,
  output logic [W-1:0] quo
);
  localparam int DW = W + 1;
  localparam int CW = $clog2(DW + 1);

  logic [DW:0]   rem_q, rem_n;
  logic [DW-1:0] acc_q, acc_n;
  logic [W-1:0]  den_q, den_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [DW:0]   trial;
  logic [DW:0]   den_ext;
  logic          fits;

  assign trial   = {rem_q[DW-1:0], acc_q[DW-1]};
  assign den_ext = {2'b00, den_q};
  assign fits    = (trial >= den_ext);

  always_comb begin
    rem_n = rem_q;
    acc_n = acc_q;
    den_n = den_q;
    cnt_n = cnt_q;
    if (load) begin
      rem_n = '0;
      acc_n = DW'(num) + DW'(den) - DW'(1);
      den_n = den;
      cnt_n = CW'(DW);
    end else if (cnt_q != '0) begin
      rem_n = fits ? (trial - den_ext) : trial;
      acc_n = {acc_q[DW-2:0], fits};
      cnt_n = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      acc_q <= '0;
      den_q <= '0;
      cnt_q <= '0;
    end else begin
      rem_q <= rem_n;
      acc_q <= acc_n;
      den_q <= den_n;
      cnt_q <= cnt_n;
    end
  end

  assign busy = (cnt_q != '0);
  assign quo  = acc_q[W-1:0];
endmodule

// File: rtl/wgt_grid_walk.sv
// Walks grid coordinates x-fastest and keeps the linear index and remain flag.
module wgt_grid_walk
  import wgt_pkg::*;
#(
  parameter int W  = 12,
  parameter int TW = 36
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clear,
  input  logic                        kill,
  input  logic                        step,
  input  logic [WGT_NDIM-1:0][W-1:0]  ext,
  input  logic [TW-1:0]               total,
  output logic [WGT_NDIM-1:0][W-1:0]  id,
  output logic [TW-1:0]               linear,
  output logic                        remain
);
  logic [WGT_NDIM-1:0][W-1:0] id_q, id_n;
  logic [TW-1:0]              lin_q, lin_n;
  logic                       rem_q, rem_n;
  logic [WGT_NDIM-1:0]        wrap;
  logic [WGT_NDIM-1:0]        carry;
  logic                       at_last;

  assign carry[0] = 1'b1;
  for (genvar d = 0; d < WGT_NDIM; d++) begin : g_axis
    assign wrap[d] = (id_q[d] == ext[d] - W'(1));
    if (d > 0) begin : g_carry
      assign carry[d] = carry[d-1] & wrap[d-1];
    end
  end

  assign at_last = (lin_q == total - TW'(1));

  always_comb begin
    id_n  = id_q;
    lin_n = lin_q;
    rem_n = rem_q;
    if (clear) begin
      id_n  = '0;
      lin_n = '0;
      rem_n = 1'b1;
    end else if (kill) begin
      rem_n = 1'b0;
    end else if (step && rem_q) begin
      if (at_last) begin
        rem_n = 1'b0;
      end else begin
        lin_n = lin_q + TW'(1);
        for (int d = 0; d < WGT_NDIM; d++) begin
          if (carry[d]) id_n[d] = wrap[d] ? '0 : id_q[d] + W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q  <= '0;
      lin_q <= '0;
      rem_q <= 1'b0;
    end else begin
      id_q  <= id_n;
      lin_q <= lin_n;
      rem_q <= rem_n;
    end
  end

  assign id     = id_q;
  assign linear = lin_q;
  assign remain = rem_q;
endmodule

// File: rtl/wg_grid_tracker.sv
module wg_grid_tracker
  import wgt_pkg::*;
#(
  parameter int DIM_W  = 12,
  parameter int ADDR_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [DIM_W-1:0]     gsize_x,
  input  logic [DIM_W-1:0]     gsize_y,
  input  logic [DIM_W-1:0]     gsize_z,
  input  logic [DIM_W-1:0]     wsize_x,
  input  logic [DIM_W-1:0]     wsize_y,
  input  logic [DIM_W-1:0]     wsize_z,
  input  logic [ADDR_W-1:0]    notify_addr,
  input  logic                 wg_issue,
  input  logic                 wg_done,
  output logic                 ready,
  output logic [DIM_W-1:0]     wg_id_x,
  output logic [DIM_W-1:0]     wg_id_y,
  output logic [DIM_W-1:0]     wg_id_z,
  output logic [3*DIM_W-1:0]   wg_linear,
  output logic                 wg_remain,
  output logic                 kernel_done,
  output logic                 done_pulse,
  output logic                 cfg_error,
  output logic                 notify_req,
  output logic [ADDR_W-1:0]    notify_addr_o,
  output logic                 dec_req
);
  localparam int TOT_W = WGT_NDIM * DIM_W;

  logic [WGT_NDIM-1:0][DIM_W-1:0] gsz, wsz, ext, ids;
  logic [WGT_NDIM-1:0]            div_busy;

  assign gsz = {gsize_z, gsize_y, gsize_x};
  assign wsz = {wsize_z, wsize_y, wsize_x};

  for (genvar d = 0; d < WGT_NDIM; d++) begin : g_div
    wgt_ceil_div #(.W(DIM_W)) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .load (start),
      .num  (gsz[d]),
      .den  (wsz[d]),
      .busy (div_busy[d]),
      .quo  (ext[d])
    );
  end

  wgt_state_e        st_q, st_n;
  logic [TOT_W-1:0]  total_q, total_n, cmpl_q, cmpl_n, total_c;
  logic              fin_q, fin_n, err_q, err_n;
  logic              done_q, done_n, ntf_q, ntf_n, dec_q, dec_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              walk_kill, walk_step;

  assign total_c = TOT_W'(ext[0]) * TOT_W'(ext[1]) * TOT_W'(ext[2]);

  always_comb begin
    st_n      = st_q;
    total_n   = total_q;
    cmpl_n    = cmpl_q;
    fin_n     = fin_q;
    err_n     = err_q;
    addr_n    = addr_q;
    done_n    = 1'b0;
    ntf_n     = 1'b0;
    dec_n     = 1'b0;
    walk_kill = 1'b0;
    if (start) begin
      st_n    = WGT_DIV;
      total_n = '0;
      cmpl_n  = '0;
      fin_n   = 1'b0;
      err_n   = (wsize_x == '0) || (wsize_y == '0) || (wsize_z == '0);
      addr_n  = notify_addr;
    end else begin
      unique case (st_q)
        WGT_DIV: begin
          if (div_busy == '0) begin
            total_n = err_q ? '0 : total_c;
            if (err_q || total_c == '0) begin
              st_n      = WGT_IDLE;
              walk_kill = 1'b1;
              done_n    = 1'b1;
              fin_n     = 1'b1;
              dec_n     = 1'b1;
              ntf_n     = (addr_q != '0);
            end else begin
              st_n = WGT_RUN;
            end
          end
        end
        WGT_RUN: begin
          if (wg_done) begin
            cmpl_n = cmpl_q + TOT_W'(1);
            if (cmpl_q + TOT_W'(1) == total_q) begin
              st_n   = WGT_IDLE;
              done_n = 1'b1;
              fin_n  = 1'b1;
              dec_n  = 1'b1;
              ntf_n  = (addr_q != '0);
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= WGT_IDLE;
      total_q <= '0;
      cmpl_q  <= '0;
      fin_q   <= 1'b0;
      err_q   <= 1'b0;
      addr_q  <= '0;
      done_q  <= 1'b0;
      ntf_q   <= 1'b0;
      dec_q   <= 1'b0;
    end else begin
      st_q    <= st_n;
      total_q <= total_n;
      cmpl_q  <= cmpl_n;
      fin_q   <= fin_n;
      err_q   <= err_n;
      addr_q  <= addr_n;
      done_q  <= done_n;
      ntf_q   <= ntf_n;
      dec_q   <= dec_n;
    end
  end

  assign walk_step = wg_issue && (st_q == WGT_RUN) && !start;

  wgt_grid_walk #(.W(DIM_W), .TW(TOT_W)) u_walk (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (start),
    .kill  (walk_kill),
    .step  (walk_step),
    .ext   (ext),
    .total (total_q),
    .id    (ids),
    .linear(wg_linear),
    .remain(wg_remain)
  );

  assign wg_id_x       = ids[0];
  assign wg_id_y       = ids[1];
  assign wg_id_z       = ids[2];
  assign ready         = (st_q == WGT_RUN);
  assign kernel_done   = fin_q;
  assign done_pulse    = done_q;
  assign cfg_error     = err_q;
  assign notify_req    = ntf_q;
  assign notify_addr_o = addr_q;
  assign dec_req       = dec_q;
endmodule

// File: rtl/wgt_grid_checker.sv
module wgt_grid_checker #(
  parameter int DIM_W  = 12,
  parameter int ADDR_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               wg_issue,
  input logic               ready,
  input logic [3*DIM_W-1:0] wg_linear,
  input logic               wg_remain,
  input logic               kernel_done,
  input logic               done_pulse,
  input logic               cfg_error,
  input logic               notify_req,
  input logic [ADDR_W-1:0]  notify_addr_o,
  input logic               dec_req
);
  localparam int TOT_W = 3 * DIM_W;

  a_r3_ready_low_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !ready);

  a_r3_issue_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && wg_issue && !start) |=> $stable(wg_linear));

  a_r4_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && wg_issue && wg_remain && !start) |=>
      ((wg_linear == $past(wg_linear) + TOT_W'(1)) || (!wg_remain && $stable(wg_linear))));

  a_r5_remain_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!wg_remain && !start) |=> !wg_remain);

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);

  a_r6_done_level: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> (kernel_done && !ready));

  a_r7_notify_gated: assert property (@(posedge clk) disable iff (!rst_n)
    notify_req |-> (done_pulse && notify_addr_o != '0));

  a_r7_dec_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> dec_req);

  a_r8_error_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (done_pulse && cfg_error) |-> !wg_remain);
endmodule

bind wg_grid_tracker wgt_grid_checker #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .wg_issue     (wg_issue),
  .ready        (ready),
  .wg_linear    (wg_linear),
  .wg_remain    (wg_remain),
  .kernel_done  (kernel_done),
  .done_pulse   (done_pulse),
  .cfg_error    (cfg_error),
  .notify_req   (notify_req),
  .notify_addr_o(notify_addr_o),
  .dec_req      (dec_req)
);

// File: tb/tb_wg_grid_tracker.sv
module tb_wg_grid_tracker;
  localparam int DIM_W  = 12;
  localparam int ADDR_W = 32;
  localparam int TOT_W  = 3 * DIM_W;

  logic clk, rst_n, start, wg_issue, wg_done;
  logic [DIM_W-1:0] gsize_x, gsize_y, gsize_z, wsize_x, wsize_y, wsize_z;
  logic [ADDR_W-1:0] notify_addr, notify_addr_o;
  logic ready, wg_remain, kernel_done, done_pulse, cfg_error, notify_req, dec_req;
  logic [DIM_W-1:0] wg_id_x, wg_id_y, wg_id_z;
  logic [TOT_W-1:0] wg_linear;

  wg_grid_tracker #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .gsize_x(gsize_x), .gsize_y(gsize_y), .gsize_z(gsize_z),
    .wsize_x(wsize_x), .wsize_y(wsize_y), .wsize_z(wsize_z),
    .notify_addr(notify_addr), .wg_issue(wg_issue), .wg_done(wg_done),
    .ready(ready), .wg_id_x(wg_id_x), .wg_id_y(wg_id_y), .wg_id_z(wg_id_z),
    .wg_linear(wg_linear), .wg_remain(wg_remain), .kernel_done(kernel_done),
    .done_pulse(done_pulse), .cfg_error(cfg_error), .notify_req(notify_req),
    .notify_addr_o(notify_addr_o), .dec_req(dec_req)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    int x;
    int y;
    int z;
    int lin;
  } wg_item_t;

  wg_item_t sbq[$];
  int n_chk = 0;
  int n_err = 0;
  int cnt_done = 0, cnt_ntf = 0, cnt_dec = 0;
  int bx, by, bz, btot, bi;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: pops an expected workgroup whenever an issue will be accepted.
  always @(negedge clk) begin
    if (rst_n && ready && wg_issue && wg_remain && !start) begin
      if (sbq.size() == 0) begin
        chk("R5", "issue accepted beyond grid", 1, 0);
      end else begin
        wg_item_t e;
        e = sbq.pop_front();
        chk("R4", "wg x", wg_id_x, e.x);
        chk("R4", "wg y", wg_id_y, e.y);
        chk("R4", "wg z", wg_id_z, e.z);
        chk("R4", "wg linear", wg_linear, e.lin);
      end
    end
    if (rst_n && done_pulse) cnt_done++;
    if (rst_n && notify_req) cnt_ntf++;
    if (rst_n && dec_req)    cnt_dec++;
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  function automatic int cdiv(input int g, input int w);
    return (g + w - 1) / w;
  endfunction

  task automatic launch(input int gx, input int gy, input int gz,
                        input int wx, input int wy, input int wz, input int addr);
    chk("R2", "scoreboard empty before launch", sbq.size(), 0);
    sbq.delete();
    gsize_x = DIM_W'(gx); gsize_y = DIM_W'(gy); gsize_z = DIM_W'(gz);
    wsize_x = DIM_W'(wx); wsize_y = DIM_W'(wy); wsize_z = DIM_W'(wz);
    notify_addr = ADDR_W'(addr);
    if (wx == 0 || wy == 0 || wz == 0) begin
      bx = 0; by = 0; bz = 0;
    end else begin
      bx = cdiv(gx, wx); by = cdiv(gy, wy); bz = cdiv(gz, wz);
    end
    btot = bx * by * bz;
    bi = 0;
    start = 1'b1;
    tick();
    start = 1'b0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 100 && !ready; i++) tick();
    chk("R3", "ready after divides", ready, 1);
  endtask

  task automatic issue_cycles(input int k);
    for (int i = 0; i < k; i++) begin
      if (bi < btot) begin
        wg_item_t e;
        e.x = bi % bx;
        e.y = (bi / bx) % by;
        e.z = bi / (bx * by);
        e.lin = bi;
        sbq.push_back(e);
        bi++;
      end
      wg_issue = 1'b1;
      tick();
    end
    wg_issue = 1'b0;
    tick();
  endtask

  task automatic complete(input int k);
    for (int i = 0; i < k; i++) begin
      wg_done = 1'b1;
      tick();
    end
    wg_done = 1'b0;
    tick();
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int d0, n0, c0;
    rst_n = 1'b0; start = 1'b0; wg_issue = 1'b0; wg_done = 1'b0;
    gsize_x = '0; gsize_y = '0; gsize_z = '0;
    wsize_x = '1; wsize_y = '1; wsize_z = '1;
    notify_addr = '0;
    repeat (3) tick();
    chk("R10", "ready", ready, 0);
    chk("R10", "remain", wg_remain, 0);
    chk("R10", "kernel_done", kernel_done, 0);
    chk("R10", "done_pulse", done_pulse, 0);
    chk("R10", "notify/dec", {notify_req, dec_req}, 0);
    chk("R10", "cfg_error", cfg_error, 0);
    rst_n = 1'b1;
    tick();

    // Kernel A: partial workgroups on every axis -> 3 x 3 x 2 = 18
    launch(10, 5, 3, 4, 2, 2, 32'h1000);
    chk("R2", "ids cleared", {wg_id_x, wg_id_y, wg_id_z}, 0);
    chk("R2", "linear cleared", wg_linear, 0);
    chk("R2", "remain set", wg_remain, 1);
    chk("R3", "ready low during divide", ready, 0);
    wg_issue = 1'b1;
    repeat (3) tick();
    wg_issue = 1'b0;
    chk("R3", "still dividing", ready, 0);
    chk("R3", "issue ignored while not ready", wg_linear, 0);
    wait_ready();
    chk("R3", "ids untouched by early issue", {wg_id_x, wg_id_y, wg_id_z}, 0);
    issue_cycles(btot + 3);
    chk("R1", "all grid items consumed", sbq.size(), 0);
    chk("R1", "issues accepted", bi, 18);
    chk("R5", "remain cleared", wg_remain, 0);
    chk("R5", "ids hold on last x", wg_id_x, 2);
    chk("R5", "ids hold on last z", wg_id_z, 1);
    chk("R5", "linear holds", wg_linear, 17);
    d0 = cnt_done; n0 = cnt_ntf; c0 = cnt_dec;
    complete(17);
    chk("R6", "no done one short", cnt_done - d0, 0);
    chk("R6", "kernel_done low one short", kernel_done, 0);
    complete(1);
    chk("R6", "single done pulse", cnt_done - d0, 1);
    chk("R6", "kernel_done level", kernel_done, 1);
    chk("R6", "ready dropped", ready, 0);
    chk("R7", "notify request", cnt_ntf - n0, 1);
    chk("R7", "dec request", cnt_dec - c0, 1);
    chk("R7", "captured address", notify_addr_o, 32'h1000);
    complete(2);
    chk("R6", "surplus completions ignored", cnt_done - d0, 1);

    // Kernel B: exact multiples -> 2 x 2 x 2 = 8, zero notify address
    launch(8, 4, 2, 4, 2, 1, 0);
    wait_ready();
    issue_cycles(btot + 1);
    chk("R1", "exact-multiple count", bi, 8);
    chk("R1", "scoreboard drained", sbq.size(), 0);
    d0 = cnt_done; n0 = cnt_ntf; c0 = cnt_dec;
    complete(8);
    chk("R6", "done after 8", cnt_done - d0, 1);
    chk("R7", "no notify with zero address", cnt_ntf - n0, 0);
    chk("R7", "dec still requested", cnt_dec - c0, 1);

    // Kernel C: lopsided 1 x 5 x 1, checks carry into y
    launch(2, 9, 1, 3, 2, 5, 32'h44);
    wait_ready();
    issue_cycles(btot + 2);
    chk("R1", "lopsided count", bi, 5);
    chk("R4", "y at last", wg_id_y, 4);
    complete(5);
    chk("R6", "kernel C done", kernel_done, 1);

    // Restart mid-run
    launch(10, 5, 3, 4, 2, 2, 32'h8);
    wait_ready();
    issue_cycles(4);
    chk("R4", "partial progress", wg_linear, 4);
    launch(6, 1, 1, 2, 1, 1, 32'h8);
    chk("R2", "restart clears linear", wg_linear, 0);
    chk("R2", "restart clears ids", {wg_id_x, wg_id_y, wg_id_z}, 0);
    chk("R2", "restart clears done", kernel_done, 0);
    wait_ready();
    issue_cycles(btot);
    complete(3);
    chk("R6", "restarted kernel done", kernel_done, 1);

    // Zero workgroup size -> error, empty grid
    d0 = cnt_done;
    launch(5, 5, 5, 1, 0, 1, 32'h10);
    chk("R8", "error flagged", cfg_error, 1);
    repeat (20) tick();
    chk("R8", "kernel_done", kernel_done, 1);
    chk("R8", "remain low", wg_remain, 0);
    chk("R8", "one done pulse", cnt_done - d0, 1);
    chk("R8", "not ready", ready, 0);
    wg_issue = 1'b1;
    repeat (3) tick();
    wg_issue = 1'b0;
    chk("R8", "issue ignored", wg_linear, 0);

    // Zero global size -> empty grid, no error
    d0 = cnt_done;
    launch(4, 0, 4, 2, 2, 2, 0);
    repeat (20) tick();
    chk("R9", "no error", cfg_error, 0);
    chk("R9", "done", kernel_done, 1);
    chk("R9", "one done pulse", cnt_done - d0, 1);
    chk("R9", "remain low", wg_remain, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule